// File: doc/BRIEF.md
# Parallel FPGA configuration master

This block loads an FPGA from a stream of configuration words. It drives the device's parallel slave configuration port. After a start request it selects the device for writing and applies a timed reset pulse on the active-low program line. It then waits for the device to release its active-low init line.

Once init is released, the block accepts the requested number of words over a valid/ready stream. It places each word on an 8- or 16-bit bus and gives it exactly one configuration clock pulse. After the last word it checks that init is still high. It then polls the done input for a bounded number of cycles. When done is seen it issues eight trailing startup clocks.

The outcome is shown on one of four sticky status flags:

- success
- init error
- done timeout
- rejected bus width

Top module: `par_cfg_master`

## Requirements
- R1: On an accepted start, chip select and read/write select go low while program stays high. Program is then driven low for exactly RESET_CYCLES system cycles and released high.
- R2: After program is released, no word is accepted (inReady stays low) for as long as the init input reads low. There is no limit on this wait.
- R3: A start with busBytes other than 1 or 2 sets widthErr and leaves busy low. Program does not pulse, no configuration clock is issued and no word is accepted.
- R4: Each word receives exactly one configuration clock pulse. The clock is high for CLK_HALF system cycles, and the data bus does not change while the clock is high.
- R5: With busBytes = 2, inData[7:0] (first byte) appears on cfgData[7:0] and inData[15:8] (second byte) on cfgData[15:8] in the same pulse. With busBytes = 1, inData[7:0] appears on cfgData[7:0] and cfgData[15:8] is 0.
- R6: Exactly wordCount words are taken from the stream. inReady is high only while the configuration clock is low and the block waits for a word, and stalls on inValid are tolerated.
- R7: If init reads low in the cycle after the last word's clock falls, initErr is set and no further clocks are issued.
- R8: Done is sampled once per cycle for up to DONE_POLLS cycles. If it is high on the last of those samples, the load succeeds. Otherwise timeoutErr is set DONE_POLLS+1 cycles after the last word's clock falls.
- R9: After done is seen, exactly 8 more configuration clock pulses are issued, and then doneOk is set.
- R10: At most one status flag is high. All flags clear on the next start and are held until then. While idle, chip select and read/write select are high and the clock is low.
- R11: A wordCount of 0 skips the data phase and goes straight from the init wait to the init check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, one cycle, accepted while idle |
| busBytes | input | 2 | Bus width in bytes for this load (1 or 2) |
| wordCount | input | LEN_W | Number of words to send |
| inData | input | 16 | Stream word, first byte in bits 7:0 |
| inValid | input | 1 | Stream word valid |
| inReady | output | 1 | Stream word taken on this edge when valid |
| cfgProgN | output | 1 | Active-low program (reset) line |
| cfgRdWrN | output | 1 | Read/write select, low for write |
| cfgCsN | output | 1 | Active-low chip select |
| cfgData | output | 16 | Configuration data bus, two byte lanes |
| cfgClk | output | 1 | Configuration clock |
| cfgInitN | input | 1 | Active-low init status from the device |
| cfgDone | input | 1 | Done status from the device |
| busy | output | 1 | Load in progress |
| doneOk | output | 1 | Load finished successfully |
| initErr | output | 1 | Init read low after the data phase |
| timeoutErr | output | 1 | Done not seen within the poll limit |
| widthErr | output | 1 | Start rejected for an unsupported bus width |

## Verification
The bench places done exactly on the last allowed poll and one cycle past it. A poll counter that is off by one would turn the first case into a timeout or let the second succeed. It also measures the timeout delay.

Single-byte loads must show a zero upper lane. A swapped or unmasked lane shows up as a data mismatch at the clock rise.

Other runs cover a long init wait, stalled input, a zero-length load and an init error after the last word. They catch a block that fetches early, miscounts words, skips the init check or issues trailing clocks after an error. Widths 0 and 3 must leave program high and the clock idle.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  typedef enum logic [1:0] {
    TMR_RESET,
    TMR_HALF,
    TMR_POLL
  } tmrSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    latchLen;
    logic    latchWord;
    logic    wide;
    logic    setClk;
    logic    clrClk;
    logic    decWord;
    logic    loadTmr;
    tmrSel_t tmrSel;
  } dpCtl_t;

endpackage

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import cfg_pkg::*;
#(
  parameter int LEN_W        = 16,
  parameter int RESET_CYCLES = 2000000,
  parameter int CLK_HALF     = 4,
  parameter int DONE_POLLS   = 10000,
  parameter int LANES        = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [LEN_W-1:0]   lenIn,
  input  logic [LANES*8-1:0] inData,
  output logic [LANES*8-1:0] cfgData,
  output logic               cfgClk,
  output logic               timerZero,
  output logic               lastWord,
  output logic               noWords
);

  localparam int MAX_A  = (RESET_CYCLES > DONE_POLLS) ? RESET_CYCLES : DONE_POLLS;
  localparam int MAX_T  = (MAX_A > CLK_HALF) ? MAX_A : CLK_HALF;
  localparam int TMR_W  = $clog2(MAX_T + 1);

  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] loadVal;
  logic [LEN_W-1:0] wordsLeft;
  logic             clkQ;

  always_comb begin
    case (ctl.tmrSel)
      TMR_RESET: loadVal = TMR_W'(RESET_CYCLES - 1);
      TMR_POLL:  loadVal = TMR_W'(DONE_POLLS - 1);
      default:   loadVal = TMR_W'(CLK_HALF - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tmr <= '0;
    else if (ctl.loadTmr) tmr <= loadVal;
    else if (tmr != '0)   tmr <= tmr - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wordsLeft <= '0;
    else if (ctl.latchLen) wordsLeft <= lenIn;
    else if (ctl.decWord && wordsLeft != '0) wordsLeft <= wordsLeft - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           clkQ <= 1'b0;
    else if (ctl.setClk) clkQ <= 1'b1;
    else if (ctl.clrClk) clkQ <= 1'b0;
  end

  // lane 0 always carries the first byte; upper lanes only in wide mode
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] laneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) laneQ <= '0;
      else if (ctl.latchWord)
        laneQ <= (g == 0 || ctl.wide) ? inData[g*8 +: 8] : 8'h00;
    end
    assign cfgData[g*8 +: 8] = laneQ;
  end

  assign cfgClk    = clkQ;
  assign timerZero = (tmr == '0);
  assign lastWord  = (wordsLeft == LEN_W'(1));
  assign noWords   = (wordsLeft == '0);

endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_pkg::*;
#(
  parameter int TRAIL_CLOCKS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] busBytes,
  input  logic       inValid,
  output logic       inReady,
  input  logic       cfgInitN,
  input  logic       cfgDone,
  input  logic       timerZero,
  input  logic       lastWord,
  input  logic       noWords,
  output dpCtl_t     ctl,
  output logic       cfgProgN,
  output logic       cfgRdWrN,
  output logic       cfgCsN,
  output logic       busy,
  output logic       doneOk,
  output logic       initErr,
  output logic       timeoutErr,
  output logic       widthErr
);

  localparam int TR_W = $clog2(TRAIL_CLOCKS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_PROG, S_WINIT, S_FETCH, S_LEAD, S_HIGH,
    S_CHECK, S_POLL, S_TRHI, S_TRLO
  } state_e;

  state_e          state;
  logic            wideQ;
  logic [TR_W-1:0] trailCnt;
  logic            okWidth;
  logic            lastTrail;

  assign okWidth   = (busBytes == 2'd1) || (busBytes == 2'd2);
  assign lastTrail = (trailCnt == TR_W'(TRAIL_CLOCKS - 1));
  assign inReady   = (state == S_FETCH);

  always_comb begin
    ctl        = '0;
    ctl.tmrSel = TMR_HALF;
    ctl.wide   = wideQ;
    case (state)
      S_IDLE:  ctl.latchLen = start && okWidth;
      S_SETUP: begin ctl.loadTmr = 1'b1; ctl.tmrSel = TMR_RESET; end
      S_FETCH: if (inValid) begin ctl.latchWord = 1'b1; ctl.loadTmr = 1'b1; end
      S_LEAD:  if (timerZero) begin ctl.setClk = 1'b1; ctl.loadTmr = 1'b1; end
      S_HIGH:  if (timerZero) begin ctl.clrClk = 1'b1; ctl.decWord = 1'b1; end
      S_CHECK: if (cfgInitN) begin ctl.loadTmr = 1'b1; ctl.tmrSel = TMR_POLL; end
      S_POLL:  if (cfgDone) begin ctl.setClk = 1'b1; ctl.loadTmr = 1'b1; end
      S_TRHI:  if (timerZero) begin ctl.clrClk = 1'b1; ctl.loadTmr = 1'b1; end
      S_TRLO:  if (timerZero && !lastTrail) begin ctl.setClk = 1'b1; ctl.loadTmr = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      wideQ      <= 1'b0;
      trailCnt   <= '0;
      cfgProgN   <= 1'b1;
      cfgRdWrN   <= 1'b1;
      cfgCsN     <= 1'b1;
      busy       <= 1'b0;
      doneOk     <= 1'b0;
      initErr    <= 1'b0;
      timeoutErr <= 1'b0;
      widthErr   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          doneOk     <= 1'b0;
          initErr    <= 1'b0;
          timeoutErr <= 1'b0;
          widthErr   <= !okWidth;
          wideQ      <= (busBytes == 2'd2);
          if (okWidth) begin
            busy     <= 1'b1;
            cfgCsN   <= 1'b0;
            cfgRdWrN <= 1'b0;
            cfgProgN <= 1'b1;
            state    <= S_SETUP;
          end
        end
        S_SETUP: begin cfgProgN <= 1'b0; state <= S_PROG; end
        S_PROG:  if (timerZero) begin cfgProgN <= 1'b1; state <= S_WINIT; end
        S_WINIT: if (cfgInitN) state <= noWords ? S_CHECK : S_FETCH;
        S_FETCH: if (inValid) state <= S_LEAD;
        S_LEAD:  if (timerZero) state <= S_HIGH;
        S_HIGH:  if (timerZero) state <= lastWord ? S_CHECK : S_FETCH;
        S_CHECK: if (cfgInitN) state <= S_POLL;
                 else begin
                   initErr <= 1'b1; busy <= 1'b0;
                   cfgCsN <= 1'b1; cfgRdWrN <= 1'b1; state <= S_IDLE;
                 end
        S_POLL:  if (cfgDone) begin trailCnt <= '0; state <= S_TRHI; end
                 else if (timerZero) begin
                   timeoutErr <= 1'b1; busy <= 1'b0;
                   cfgCsN <= 1'b1; cfgRdWrN <= 1'b1; state <= S_IDLE;
                 end
        S_TRHI:  if (timerZero) state <= S_TRLO;
        S_TRLO:  if (timerZero) begin
                   if (lastTrail) begin
                     doneOk <= 1'b1; busy <= 1'b0;
                     cfgCsN <= 1'b1; cfgRdWrN <= 1'b1; state <= S_IDLE;
                   end else begin
                     trailCnt <= trailCnt + 1'b1; state <= S_TRHI;
                   end
                 end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/par_cfg_master.sv
module par_cfg_master
  import cfg_pkg::*;
#(
  parameter int LEN_W        = 16,
  parameter int RESET_CYCLES = 2000000,
  parameter int CLK_HALF     = 4,
  parameter int DONE_POLLS   = 10000,
  parameter int TRAIL_CLOCKS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       busBytes,
  input  logic [LEN_W-1:0] wordCount,
  input  logic [15:0]      inData,
  input  logic             inValid,
  output logic             inReady,
  output logic             cfgProgN,
  output logic             cfgRdWrN,
  output logic             cfgCsN,
  output logic [15:0]      cfgData,
  output logic             cfgClk,
  input  logic             cfgInitN,
  input  logic             cfgDone,
  output logic             busy,
  output logic             doneOk,
  output logic             initErr,
  output logic             timeoutErr,
  output logic             widthErr
);

  dpCtl_t ctl;
  logic   timerZero;
  logic   lastWord;
  logic   noWords;

  cfg_ctrl #(.TRAIL_CLOCKS(TRAIL_CLOCKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busBytes(busBytes),
    .inValid(inValid), .inReady(inReady), .cfgInitN(cfgInitN), .cfgDone(cfgDone),
    .timerZero(timerZero), .lastWord(lastWord), .noWords(noWords), .ctl(ctl),
    .cfgProgN(cfgProgN), .cfgRdWrN(cfgRdWrN), .cfgCsN(cfgCsN), .busy(busy),
    .doneOk(doneOk), .initErr(initErr), .timeoutErr(timeoutErr), .widthErr(widthErr)
  );

  cfg_datapath #(
    .LEN_W(LEN_W), .RESET_CYCLES(RESET_CYCLES), .CLK_HALF(CLK_HALF),
    .DONE_POLLS(DONE_POLLS), .LANES(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lenIn(wordCount), .inData(inData),
    .cfgData(cfgData), .cfgClk(cfgClk), .timerZero(timerZero),
    .lastWord(lastWord), .noWords(noWords)
  );

endmodule

// File: rtl/par_cfg_master_chk.sv
module par_cfg_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inReady,
  input logic        cfgProgN,
  input logic        cfgRdWrN,
  input logic        cfgCsN,
  input logic [15:0] cfgData,
  input logic        cfgClk,
  input logic        busy,
  input logic        doneOk,
  input logic        initErr,
  input logic        timeoutErr,
  input logic        widthErr
);

  // R1
  prog_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgProgN |-> busy && !cfgCsN && !cfgRdWrN);

  // R1
  start_prog_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> cfgProgN);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgClk && $past(cfgClk) |-> $stable(cfgData));

  // R6
  ready_clk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !cfgClk && busy);

  // R10
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({doneOk, initErr, timeoutErr, widthErr}));

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> cfgCsN && cfgRdWrN && cfgProgN && !cfgClk);

  // R9
  ok_clk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneOk) |-> !cfgClk && !busy);

endmodule

bind par_cfg_master par_cfg_master_chk u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .cfgProgN(cfgProgN),
  .cfgRdWrN(cfgRdWrN), .cfgCsN(cfgCsN), .cfgData(cfgData), .cfgClk(cfgClk),
  .busy(busy), .doneOk(doneOk), .initErr(initErr), .timeoutErr(timeoutErr),
  .widthErr(widthErr)
);

// File: tb/sim_par_cfg_master.sv
module sim_par_cfg_master;

  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 2;
  localparam int RST   = 10;
  localparam int POLLS = 20;

  typedef struct packed {
    logic [1:0] width;
    logic [7:0] len;
    logic       stall;
    logic [1:0] mode;    // 0 done at doneAt, 1 init error, 2 never done
    logic [7:0] doneAt;
    logic [7:0] initDly;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 8'd5, 1'b0, 2'd0, 8'd1,  8'd2},
    '{2'd1, 8'd4, 1'b1, 2'd0, 8'd3,  8'd40},
    '{2'd2, 8'd0, 1'b0, 2'd0, 8'd1,  8'd3},
    '{2'd2, 8'd3, 1'b1, 2'd0, 8'd20, 8'd1},
    '{2'd1, 8'd2, 1'b0, 2'd0, 8'd21, 8'd1},
    '{2'd2, 8'd3, 1'b0, 2'd1, 8'd1,  8'd2},
    '{2'd3, 8'd3, 1'b0, 2'd0, 8'd1,  8'd2},
    '{2'd0, 8'd2, 1'b0, 2'd0, 8'd1,  8'd2},
    '{2'd2, 8'd2, 1'b0, 2'd2, 8'd1,  8'd2}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  busBytes = 2'd0;
  logic [15:0] wordCount = '0;
  logic [15:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        cfgProgN, cfgRdWrN, cfgCsN, cfgClk;
  logic [15:0] cfgData;
  logic        cfgInitN = 1'b0;
  logic        cfgDone = 1'b0;
  logic        busy, doneOk, initErr, timeoutErr, widthErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_cfg_master #(
    .LEN_W(16), .RESET_CYCLES(RST), .CLK_HALF(HALF), .DONE_POLLS(POLLS), .TRAIL_CLOCKS(8)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .busBytes(busBytes), .wordCount(wordCount),
    .inData(inData), .inValid(inValid), .inReady(inReady), .cfgProgN(cfgProgN),
    .cfgRdWrN(cfgRdWrN), .cfgCsN(cfgCsN), .cfgData(cfgData), .cfgClk(cfgClk),
    .cfgInitN(cfgInitN), .cfgDone(cfgDone), .busy(busy), .doneOk(doneOk),
    .initErr(initErr), .timeoutErr(timeoutErr), .widthErr(widthErr)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input int i);
    return 16'h3C5A ^ 16'(i * 16'h1111 + i * 3);
  endfunction

  function automatic logic [15:0] expBus(input int i, input logic [1:0] w);
    logic [15:0] d = word(i);
    return (w == 2'd2) ? d : {8'h00, d[7:0]};
  endfunction

  // current test settings
  logic [1:0] curWidth = 0;
  int  curLen = 0, curMode = 0, curDoneAt = 0, curInitDly = 0;
  bit  curStall = 0;
  bit  clearMon = 0;

  // monitor state
  int  rises, falls, dataErrs, progLow, pollCyc, timeoutAt, r2Err, highLen, initCnt, sampleIdx;
  int  feedIdx;
  bit  prevClk, prevProg, s0Seen, toSeen, initArm, lenZeroPend;
  logic [15:0] holdBus;

  always @(posedge clk) begin
    if (clearMon) feedIdx <= 0;
    else if (inValid && inReady) feedIdx <= feedIdx + 1;
  end

  always @(negedge clk) begin
    if (clearMon) begin
      rises = 0; falls = 0; dataErrs = 0; progLow = 0; pollCyc = 0; timeoutAt = -1;
      r2Err = 0; highLen = 0; initCnt = 0; sampleIdx = 0; prevClk = 0; prevProg = 1;
      s0Seen = 0; toSeen = 0; initArm = 0; lenZeroPend = 0; holdBus = '0;
      cfgInitN = 1'b0; cfgDone = 1'b0; inValid = 1'b0;
    end else begin
      sampleIdx++;
      if (s0Seen) pollCyc++;
      if (lenZeroPend) begin s0Seen = 1; pollCyc = 0; lenZeroPend = 0; end
      if (cfgClk && !prevClk) begin
        if (rises < curLen && cfgData !== expBus(rises, curWidth)) dataErrs++;
        holdBus = cfgData; rises++; highLen = 1;
      end else if (cfgClk) begin
        highLen++;
        if (cfgData !== holdBus) dataErrs++;
      end
      if (!cfgClk && prevClk) begin
        if (highLen != HALF) dataErrs++;
        falls++;
        if (curLen != 0 && falls == curLen && !s0Seen) begin s0Seen = 1; pollCyc = 0; end
      end
      if (!cfgProgN) progLow++;
      if (cfgProgN && !prevProg) begin initCnt = curInitDly; initArm = 1; end
      else if (initArm) begin
        if (initCnt == 0) begin
          cfgInitN = 1'b1; initArm = 0;
          if (curLen == 0) lenZeroPend = 1;
        end else initCnt--;
      end
      if (curMode == 1 && curLen != 0 && cfgClk && rises == curLen) cfgInitN = 1'b0;
      if (s0Seen && curMode == 0 && pollCyc == curDoneAt) cfgDone = 1'b1;
      if (timeoutErr && !toSeen) begin toSeen = 1; timeoutAt = pollCyc; end
      if (!cfgInitN && inReady) r2Err++;
      inValid = (feedIdx < curLen) && !(curStall && sampleIdx[0]);
      inData  = word(feedIdx);
      prevClk = cfgClk; prevProg = cfgProgN;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    // R10 reset state
    chk(cfgProgN && cfgCsN && cfgRdWrN && !cfgClk, "R10 reset lines", {cfgProgN, cfgCsN, cfgRdWrN, cfgClk}, 4'b1110);
    chk({busy, doneOk, initErr, timeoutErr, widthErr, inReady} == 0, "R10 reset flags",
        {busy, doneOk, initErr, timeoutErr, widthErr, inReady}, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t vc = VECS[v];
      bit wOk = (vc.width == 2'd1 || vc.width == 2'd2);
      int expFlags;
      int expRises;
      if (!wOk)                  expFlags = 4'b0001;
      else if (vc.mode == 2'd1)  expFlags = 4'b0100;
      else if (vc.mode == 2'd2 || vc.doneAt > POLLS) expFlags = 4'b0010;
      else                       expFlags = 4'b1000;
      expRises = !wOk ? 0 : (expFlags == 4'b1000) ? vc.len + 8 : vc.len;

      curWidth = vc.width; curLen = vc.len; curMode = vc.mode;
      curDoneAt = vc.doneAt; curInitDly = vc.initDly; curStall = vc.stall;
      clearMon = 1'b1;
      @(negedge clk); #1 clearMon = 1'b0;
      start = 1'b1; busBytes = vc.width; wordCount = 16'(vc.len);
      @(negedge clk); #1 start = 1'b0;
      // R1 / R3 / R10 at start
      chk(busy == wOk, "R3 busy at start", busy, wOk);
      chk({doneOk, initErr, timeoutErr} == 3'b000 && widthErr == !wOk, "R10 flags cleared on start",
          {doneOk, initErr, timeoutErr, widthErr}, {3'b000, !wOk});
      if (wOk)
        chk(!cfgCsN && !cfgRdWrN && cfgProgN, "R1 select lines", {cfgCsN, cfgRdWrN, cfgProgN}, 3'b001);
      for (int t = 0; t < 3000 && busy; t++) @(negedge clk);
      @(negedge clk); #1;
      chk({doneOk, initErr, timeoutErr, widthErr} == expFlags, "R7 R8 R9 outcome",
          {doneOk, initErr, timeoutErr, widthErr}, expFlags);
      chk(rises == expRises, "R4 R9 clock pulse count", rises, expRises);
      chk(dataErrs == 0, "R4 R5 data and clock shape", dataErrs, 0);
      chk(progLow == (wOk ? RST : 0), "R1 R3 program pulse width", progLow, wOk ? RST : 0);
      chk(feedIdx == (wOk ? vc.len : 0), "R6 R11 words accepted", feedIdx, wOk ? vc.len : 0);
      chk(r2Err == 0, "R2 no fetch before init", r2Err, 0);
      if (expFlags == 4'b0010)
        chk(timeoutAt == POLLS + 1, "R8 timeout delay", timeoutAt, POLLS + 1);
      repeat (5) @(negedge clk);
      #1;
      chk({doneOk, initErr, timeoutErr, widthErr} == expFlags && cfgCsN && cfgRdWrN,
          "R10 flags held and lines released", {doneOk, initErr, timeoutErr, widthErr}, expFlags);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule